// File: doc/BRIEF.md
# Metastability Event Counter Controller

This block runs the bookkeeping side of a metastability experiment. Two external detector circuits each raise a flag on the system clock when they see a sampling upset. The controller picks one of the two flags, shows it on a real-time output, and counts flagged cycles in a wrapping 8-bit counter. The counter only runs after a fixed warm-up period that follows reset or a rising enable. This period lets the analogue-like oscillator and delay chains around the block settle first.

The block also chooses the stimulus that goes to the sampling flip-flop. Normally it passes an asynchronous data source through unchanged. When an asynchronous calibration request is raised, the request first crosses a two-flop synchroniser. The stimulus then switches to a register that toggles on every rising clock edge. This stimulus is aligned to the clock, so a healthy detector path should count nothing while it is in use.

The detector select and the other control inputs are pseudo-static. Only the calibration request and the asynchronous data source may change at run time.

Top module: `meta_event_ctrl`

## Requirements
- R1: While `rst_n` is low, `event_count` is 0 and `ready` is 0. The synchroniser is also cleared, so `stim_out` equals `async_stim`.
- R2: After reset is released with `enable` high, `ready` is 0 after the first 30 rising edges and 1 after the 31st. No event is counted while `ready` is 0.
- R3: When `enable` is low at a rising edge, `ready` is 0 after that edge and `event_count` keeps its value. When `enable` returns high, the warm-up of R2 starts again from zero.
- R4: At a rising edge where `ready` and `enable` are both 1 and the selected flag is 1, `event_count` increases by exactly one. Otherwise it does not change.
- R5: The count wraps from 255 to 0.
- R6: `det_sel` = 0 routes `det_flag_a`, and `det_sel` = 1 routes `det_flag_b`, to `event_flag` in the same cycle. The routed flag is the one the counter uses.
- R7: The unselected detector flag has no effect on `event_flag` or `event_count`.
- R8: A change of `cal_req` is not visible on `stim_out` after the first rising edge that samples it. It takes effect right after the second rising edge.
- R9: While calibration is active, `stim_out` takes the opposite value after every rising edge, whatever `async_stim` does.
- R10: After calibration ends, again two edges after `cal_req` falls, `stim_out` follows `async_stim` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; a rising level restarts the warm-up |
| cal_req | input | 1 | Asynchronous calibration request |
| det_sel | input | 1 | Detector choice: 0 = detector A, 1 = detector B |
| det_flag_a | input | 1 | Event flag from detector A (clock domain) |
| det_flag_b | input | 1 | Event flag from detector B (clock domain) |
| async_stim | input | 1 | Asynchronous data source for measurement |
| stim_out | output | 1 | Stimulus sent to the flip-flop under test |
| event_flag | output | 1 | Selected detector flag, real time |
| event_count | output | 8 | Wrapping count of flagged cycles |
| ready | output | 1 | Warm-up finished; counting allowed |

## Verification
`event_flag` is combinational, so the bench checks it 1 ns after driving the flags, within the same cycle. `event_count` and `ready` change one register stage after the edge that samples their inputs. The bench drives inputs at the falling edge and reads these results at the next falling edge. For warm-up, the bench counts rising edges since release and expects `ready` after exactly 31 of them, and the first count one edge later. A calibration change passes through two flops, so `stim_out` is read after one edge (expected unchanged) and after two edges (expected switched). Toggling is then checked by comparing the values at consecutive falling edges.

// File: rtl/mec_pkg.sv
package mec_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned WARM_W_DEF = 5;
  localparam int unsigned SYNC_N_DEF = 2;

  // next value of a wrapping event count
  function automatic logic [CNT_W_DEF-1:0] step_count(input logic [CNT_W_DEF-1:0] cur,
                                                      input logic               hit);
    return hit ? cur + 1'b1 : cur;
  endfunction

  // route one of two detector flags
  function automatic logic pick_flag(input logic sel, input logic fa, input logic fb);
    return sel ? fb : fa;
  endfunction
endpackage

// File: rtl/mec_sync.sv
module mec_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_first,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_first = chain[0];
  assign q_sync  = chain[STAGES-1];
endmodule

// File: rtl/mec_warmup.sv
module mec_warmup #(
  parameter int unsigned WARM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic [WARM_W-1:0] warm_cnt,
  output logic              ready
);
  localparam logic [WARM_W-1:0] WARM_LAST = {WARM_W{1'b1}};

  logic at_last;
  assign at_last = (warm_cnt == WARM_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        warm_cnt <= '0;
    else if (!enable)  warm_cnt <= '0;
    else if (!at_last) warm_cnt <= warm_cnt + 1'b1;
  end

  assign ready = at_last;
endmodule

// File: rtl/mec_event_counter.sv
module mec_event_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = hit ? count + 1'b1 : count;
    if (!count_en) nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end
endmodule

// File: rtl/mec_stim_sel.sv
module mec_stim_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_active,
  input  logic async_stim,
  output logic cal_tog,
  output logic stim_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_tog <= 1'b0;
    else        cal_tog <= ~cal_tog;
  end

  assign stim_out = cal_active ? cal_tog : async_stim;
endmodule

// File: rtl/meta_event_ctrl.sv
module meta_event_ctrl
  import mec_pkg::*;
#(
  parameter int unsigned WARM_W = WARM_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 cal_req,
  input  logic                 det_sel,
  input  logic                 det_flag_a,
  input  logic                 det_flag_b,
  input  logic                 async_stim,
  output logic                 stim_out,
  output logic                 event_flag,
  output logic [CNT_W_DEF-1:0] event_count,
  output logic                 ready
);
  // named internal events, brought out for the checker
  logic              sync_first;
  logic              cal_active;
  logic              cal_tog;
  logic              count_en;
  logic [WARM_W-1:0] warm_cnt;

  mec_sync #(.STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cal_req),
    .q_first (sync_first),
    .q_sync  (cal_active)
  );

  mec_warmup #(.WARM_W(WARM_W)) u_warm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .warm_cnt (warm_cnt),
    .ready    (ready)
  );

  assign event_flag = pick_flag(det_sel, det_flag_a, det_flag_b);
  assign count_en   = ready & enable;

  mec_event_counter #(.CNT_W(CNT_W_DEF)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .hit      (event_flag),
    .count    (event_count)
  );

  mec_stim_sel u_stim (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_active (cal_active),
    .async_stim (async_stim),
    .cal_tog    (cal_tog),
    .stim_out   (stim_out)
  );
endmodule

// File: rtl/mec_checks.sv
module mec_checks #(
  parameter int unsigned WARM_W = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       det_sel,
  input logic       det_flag_a,
  input logic       det_flag_b,
  input logic       event_flag,
  input logic [7:0] event_count,
  input logic       ready,
  input logic       sync_first,
  input logic       cal_active,
  input logic       stim_out
);
  localparam int unsigned WARM_LAST = (1 << WARM_W) - 1;

  // enabled edges since reset or enable drop, saturating
  int unsigned en_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_run <= 0;
    else if (!enable) en_run <= 0;
    else if (en_run < WARM_LAST + 4) en_run <= en_run + 1;
  end

  a_r2_warm_window: assert property (@(posedge clk) disable iff (!rst_n)
    ready == (en_run >= WARM_LAST));

  a_r3_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ready && $stable(event_count));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enable && event_flag) |=> event_count == 8'($past(event_count) + 8'd1));

  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && enable && event_flag) |=> $stable(event_count));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enable && event_flag && event_count == 8'd255) |=> event_count == 8'd0);

  a_r6_route_a: assert property (@(posedge clk) disable iff (!rst_n)
    !det_sel |-> event_flag == det_flag_a);

  a_r7_route_b: assert property (@(posedge clk) disable iff (!rst_n)
    det_sel |-> event_flag == det_flag_b);

  a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_active) |-> $past(sync_first));

  a_r9_cal_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && $past(cal_active)) |-> stim_out != $past(stim_out));
endmodule

bind meta_event_ctrl mec_checks #(.WARM_W(WARM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .det_sel     (det_sel),
  .det_flag_a  (det_flag_a),
  .det_flag_b  (det_flag_b),
  .event_flag  (event_flag),
  .event_count (event_count),
  .ready       (ready),
  .sync_first  (sync_first),
  .cal_active  (cal_active),
  .stim_out    (stim_out)
);

// File: tb/sim_meta_event_ctrl.sv
module sim_meta_event_ctrl;
  localparam time PERIOD = 10ns;
  localparam int  WARM   = 31;

  logic clk = 1'b0;
  logic rst_n, enable, cal_req, det_sel, det_flag_a, det_flag_b, async_stim;
  logic stim_out, event_flag, ready;
  logic [7:0] event_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int model  = 0;

  always #(PERIOD/2) clk = ~clk;

  meta_event_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cal_req(cal_req),
    .det_sel(det_sel), .det_flag_a(det_flag_a), .det_flag_b(det_flag_b),
    .async_stim(async_stim), .stim_out(stim_out), .event_flag(event_flag),
    .event_count(event_count), .ready(ready)
  );

  // {sel, flag_a, flag_b, expected selected flag}
  localparam bit [3:0] VEC [10] = '{
    4'b0_1_0_1, 4'b0_0_1_0, 4'b1_0_1_1, 4'b1_1_0_0, 4'b0_1_1_1,
    4'b1_1_1_1, 4'b0_0_0_0, 4'b1_0_0_0, 4'b1_0_1_1, 4'b0_1_0_1
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic prev;
    rst_n = 0; enable = 1; cal_req = 0; det_sel = 0;
    det_flag_a = 1; det_flag_b = 1; async_stim = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", event_count, 0);
    chk("R1 ready", ready, 0);
    chk("R1 stim hi", stim_out, 1);
    async_stim = 0; #1;
    chk("R1 stim lo", stim_out, 0);

    // R2 warm-up with flags high
    rst_n = 1;
    for (int k = 1; k <= WARM; k++) begin
      @(negedge clk);
      if (k >= WARM - 1) chk("R2 ready edge", ready, (k == WARM) ? 1 : 0);
      chk("R2 no count in warm-up", event_count, 0);
    end
    @(negedge clk);
    chk("R2 first count", event_count, 1);
    model = 1;
    det_flag_a = 0; det_flag_b = 0;

    // R6/R7/R4 vector walk
    for (int i = 0; i < 10; i++) begin
      det_sel = VEC[i][3]; det_flag_a = VEC[i][2]; det_flag_b = VEC[i][1];
      #1;
      chk("R6 event_flag", event_flag, VEC[i][0]);
      @(negedge clk);
      model = (model + VEC[i][0]) % 256;
      chk("R4 R7 count", event_count, model);
    end

    // R5 wrap
    det_sel = 0; det_flag_a = 1; det_flag_b = 0;
    while (model != 255) begin
      @(negedge clk);
      model++;
    end
    chk("R5 at 255", event_count, 255);
    @(negedge clk);
    chk("R5 wrap to 0", event_count, 0);
    model = 0;
    det_flag_a = 0;

    // R8/R9 calibration entry
    async_stim = 1;
    cal_req = 1;
    @(negedge clk);
    chk("R8 not after one edge", stim_out, 1);
    @(negedge clk);
    prev = stim_out;
    @(negedge clk);
    chk("R9 toggle 1", stim_out, !prev);
    prev = stim_out;
    async_stim = 0;
    @(negedge clk);
    chk("R9 toggle 2", stim_out, !prev);
    prev = stim_out;
    @(negedge clk);
    chk("R9 toggle 3", stim_out, !prev);

    // R10 calibration exit
    async_stim = 1;
    cal_req = 0;
    prev = stim_out;
    @(negedge clk);
    chk("R10 still toggling", stim_out, !prev);
    @(negedge clk);
    chk("R10 back to source", stim_out, 1);
    async_stim = 0; #1;
    chk("R10 follows source", stim_out, 0);

    // R3 enable drop with flag high
    det_flag_a = 1;
    enable = 0;
    @(negedge clk);
    chk("R3 ready low", ready, 0);
    chk("R3 count held", event_count, model);
    repeat (2) @(negedge clk);
    chk("R3 count held long", event_count, model);
    enable = 1;
    for (int k = 1; k <= WARM; k++) begin
      @(negedge clk);
      if (k >= WARM - 1) chk("R3 re-warm ready", ready, (k == WARM) ? 1 : 0);
    end
    chk("R3 no count in re-warm", event_count, model);
    @(negedge clk);
    chk("R3 count resumes", event_count, model + 1);

    // R1 reset clears count mid-run
    rst_n = 0; #1;
    chk("R1 async clear", event_count, 0);
    finish_run();
  end
endmodule